// File: doc/BRIEF.md
# Three-Step Code Lock Controller

This block is a synchronous keypad lock. A user enters a sequence of three 4-bit values. Each value is marked by a one-cycle entry strobe. The lock opens only when every value matches the code word stored for its step, in order. A single wrong entry at any step sends the lock to an error state. Once open, or once in error, the lock ignores all further entries until reset.

The three code words sit in small registers. They are written through a write enable, a slot index and a data bus, and writes are accepted only while reset is held.

The state register uses four bits, and its bits double as outputs:

- The low three bits form a one-hot select that picks the code word for the current step.
- The top bit is the open output.

Because of this, no output decoding stands between the state register and the pins. Both outputs are therefore registered and change only on a rising clock edge.

Top module: `seq_lock_top`

## Requirements
- R1: While reset is high on a rising edge, the next state is "expect first value": `step_sel` = 3'b001 and `unlocked` = 0.
- R2: A code write is accepted only while reset is high. Slot index 0, 1 and 2 hold the first, second and third code word, and slot index 3 stores nothing. A write while reset is low leaves every code word unchanged.
- R3: On a strobe whose value equals the current step's code word, the lock advances one step per edge: `step_sel` goes 001 → 010 → 100. After the third match, `unlocked` = 1 and `step_sel` = 000.
- R4: On a strobe whose value differs from the current step's code word, at any of the three steps, the lock enters the error state: `unlocked` = 0 and `step_sel` = 000.
- R5: A cycle without a strobe leaves both outputs unchanged, whatever the value input holds.
- R6: In the open state, strobes with any value are ignored, and the lock stays open until reset.
- R7: In the error state, strobes are ignored, including ones carrying the correct code, and the lock stays closed until reset.
- R8: Reset has priority over a strobe on the same edge, and it works from every state, including open and error.
- R9: Equality needs all four bits to agree: a value that differs from the code word in any single bit counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset; also opens the code write window |
| key_stb | input | 1 | One-cycle marker of a new entered value |
| key_val | input | 4 | Entered value |
| cfg_we | input | 1 | Code word write enable (honoured only during reset) |
| cfg_idx | input | 2 | Code slot index: 0 = first, 1 = second, 2 = third |
| cfg_data | input | 4 | Code word to store |
| unlocked | output | 1 | 1 = open, 0 = closed; the top state bit |
| step_sel | output | 3 | One-hot step select, the low state bits; 000 when open or in error |

## Verification
The hardest situations to reach are those where a correct-looking strobe must be refused:

- a right value arriving after the error state has already been entered;
- a write arriving outside the reset window.

For the first, the stimulus walks the lock to each of the three steps in turn, injects one wrong value, and then replays the full correct code, which must not open the lock. For the second, the stimulus writes garbage to the slots with reset low, then resets and checks that the original sequence still opens the lock. It also rewrites a slot inside the reset window to show that a legal write does take effect. Single-bit corruptions of the first value show that every comparator bit counts.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int unsigned LOCK_VAL_W = 4;
  localparam int unsigned LOCK_STEPS = 3;

  // true when the state vector names one of the entry steps
  function automatic logic in_entry_step(input logic [LOCK_STEPS:0] st);
    return (st[LOCK_STEPS-1:0] != '0);
  endfunction
endpackage

// File: rtl/lock_code_store.sv
module lock_code_store #(
  parameter int unsigned VAL_W = 4,
  parameter int unsigned STEPS = 3,
  localparam int unsigned IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [VAL_W-1:0]            wr_data,
  output logic [STEPS-1:0][VAL_W-1:0] codes
);

  logic [STEPS-1:0][VAL_W-1:0] code_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst && wr_en && (wr_idx == IDX_W'(g))) begin
        code_q[g] <= wr_data;
      end
    end
  end

  assign codes = code_q;

  AST_CODES_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(code_q)); // R2

endmodule

// File: rtl/lock_code_match.sv
module lock_code_match #(
  parameter int unsigned VAL_W = 4,
  parameter int unsigned STEPS = 3
) (
  input  logic [STEPS-1:0][VAL_W-1:0] codes,
  input  logic [STEPS-1:0]            sel,
  input  logic [VAL_W-1:0]            value,
  output logic                        equal
);

  logic [VAL_W-1:0] picked;
  logic [VAL_W-1:0] bit_same;

  // one-hot AND-OR multiplexer
  always_comb begin
    picked = '0;
    for (int i = 0; i < STEPS; i++) begin
      picked = picked | (codes[i] & {VAL_W{sel[i]}});
    end
  end

  // per-bit XNOR, then all bits must agree
  for (genvar b = 0; b < VAL_W; b++) begin : g_bit
    assign bit_same[b] = ~(picked[b] ^ value[b]);
  end

  assign equal = &bit_same;

  always_comb begin
    AST_SEL_ONEHOT0: assert ($onehot0(sel)); // R3
  end

endmodule

// File: rtl/lock_step_fsm.sv
module lock_step_fsm
  import lock_pkg::*;
#(
  parameter int unsigned STEPS = LOCK_STEPS,
  localparam int unsigned ST_W = STEPS + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stb,
  input  logic            equal,
  output logic [ST_W-1:0] state
);

  localparam logic [ST_W-1:0] ST_FIRST = ST_W'(1);
  localparam logic [ST_W-1:0] ST_ERR   = '0;
  localparam logic [ST_W-1:0] ST_OPEN  = ST_W'(1) << STEPS;

  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] state_d;
  logic            at_step;

  assign at_step = (state_q[STEPS-1:0] != '0);

  always_comb begin
    state_d = state_q;
    if (stb && at_step) begin
      state_d = equal ? (state_q << 1) : ST_ERR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FIRST;
    else     state_q <= state_d;
  end

  assign state = state_q;

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(state_q)); // R3
  AST_MISMATCH_ERR: assert property (@(posedge clk) disable iff (rst)
    (stb && !equal && at_step) |=> (state_q == ST_ERR)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(state_q)); // R5
  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN) |=> (state_q == ST_OPEN)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERR) |=> (state_q == ST_ERR)); // R7
  AST_RESET_WINS: assert property (@(posedge clk)
    rst |=> (state_q == ST_FIRST)); // R8

endmodule

// File: rtl/seq_lock_top.sv
module seq_lock_top
  import lock_pkg::*;
#(
  parameter int unsigned VAL_W = LOCK_VAL_W,
  parameter int unsigned STEPS = LOCK_STEPS,
  localparam int unsigned IDX_W = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             key_stb,
  input  logic [VAL_W-1:0] key_val,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [VAL_W-1:0] cfg_data,
  output logic             unlocked,
  output logic [STEPS-1:0] step_sel
);

  logic [STEPS-1:0][VAL_W-1:0] codes;
  logic [STEPS:0]              state;
  logic                        equal;

  lock_code_store #(.VAL_W(VAL_W), .STEPS(STEPS)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_idx  (cfg_idx),
    .wr_data (cfg_data),
    .codes   (codes)
  );

  lock_code_match #(.VAL_W(VAL_W), .STEPS(STEPS)) u_match (
    .codes (codes),
    .sel   (state[STEPS-1:0]),
    .value (key_val),
    .equal (equal)
  );

  lock_step_fsm #(.STEPS(STEPS)) u_fsm (
    .clk   (clk),
    .rst   (rst),
    .stb   (key_stb),
    .equal (equal),
    .state (state)
  );

  // outputs are state bits directly: no decode
  assign step_sel = state[STEPS-1:0];
  assign unlocked = state[STEPS];

  AST_OPEN_NO_SEL: assert property (@(posedge clk) disable iff (rst)
    unlocked |-> (step_sel == '0)); // R3
  AST_RESET_CLOSED: assert property (@(posedge clk)
    $fell(rst) |-> (!unlocked && step_sel == STEPS'(1))); // R1

endmodule

// File: tb/test_seq_lock_top.sv
module test_seq_lock_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_stb = 1'b0;
  logic [3:0] key_val = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [3:0] cfg_data = '0;
  logic       unlocked;
  logic [2:0] step_sel;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  localparam logic [3:0] K1 = 4'h5, K2 = 4'hA, K3 = 4'h3;

  always #2 clk = ~clk;

  seq_lock_top i_seq_lock_top (
    .clk(clk), .rst(rst), .key_stb(key_stb), .key_val(key_val),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .unlocked(unlocked), .step_sel(step_sel)
  );

  task automatic chk(input string req, input logic ex_open, input logic [2:0] ex_sel);
    n_chk++;
    if (unlocked !== ex_open || step_sel !== ex_sel) begin
      n_bad++;
      $display("FAIL %s: got open=%b sel=%b, expected open=%b sel=%b",
               req, unlocked, step_sel, ex_open, ex_sel);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [3:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // reset with the default code words loaded
  task automatic do_reset();
    @(negedge clk); rst = 1'b1; key_stb = 1'b0;
    wr(2'd0, K1); wr(2'd1, K2); wr(2'd2, K3);
    @(negedge clk); rst = 1'b0;
  endtask

  // strobe one value; outputs sampled one negedge after the active edge
  task automatic press(input logic [3:0] v);
    @(negedge clk); key_stb = 1'b1; key_val = v;
    @(negedge clk); key_stb = 1'b0; key_val = ~v;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 reset state", 1'b0, 3'b001);
  endtask

  task automatic t_good_seq();
    do_reset();
    press(K1); chk("R3 step2", 1'b0, 3'b010);
    repeat (3) @(negedge clk);
    chk("R5 idle hold", 1'b0, 3'b010);
    press(K2); chk("R3 step3", 1'b0, 3'b100);
    press(K3); chk("R3 opened", 1'b1, 3'b000);
  endtask

  task automatic t_open_sticky();
    press(4'hF); chk("R6 open ignores wrong", 1'b1, 3'b000);
    press(K1);   chk("R6 open ignores code", 1'b1, 3'b000);
    // reset out of open state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 reset from open", 1'b0, 3'b001);
  endtask

  task automatic t_mismatch(input int k);
    logic [3:0] seq [3];
    seq[0] = K1; seq[1] = K2; seq[2] = K3;
    do_reset();
    for (int i = 0; i < k; i++) press(seq[i]);
    press(~seq[k]);
    chk($sformatf("R4 mismatch at step %0d", k + 1), 1'b0, 3'b000);
    for (int i = 0; i < 3; i++) press(seq[i]);
    chk("R7 error ignores correct code", 1'b0, 3'b000);
  endtask

  task automatic t_bits();
    for (int b = 0; b < 4; b++) begin
      do_reset();
      press(K1 ^ (4'b1 << b));
      chk($sformatf("R9 single-bit diff bit %0d", b), 1'b0, 3'b000);
    end
  endtask

  task automatic t_reset_prio();
    do_reset();
    press(K1);
    @(negedge clk); rst = 1'b1; key_stb = 1'b1; key_val = K2;
    @(negedge clk); rst = 1'b0; key_stb = 1'b0;
    chk("R8 reset beats strobe", 1'b0, 3'b001);
    press(4'h0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R8 reset from error", 1'b0, 3'b001);
  endtask

  task automatic t_load_window();
    do_reset();
    // writes outside reset must be dropped
    wr(2'd0, 4'hF); wr(2'd1, 4'hF); wr(2'd2, 4'hF);
    @(negedge clk); rst = 1'b1;
    wr(2'd3, 4'h0);              // slot 3 stores nothing
    @(negedge clk); rst = 1'b0;
    press(K1); press(K2); press(K3);
    chk("R2 writes outside reset ignored", 1'b1, 3'b000);
    // a write inside reset takes effect
    @(negedge clk); rst = 1'b1;
    wr(2'd1, 4'hC);
    @(negedge clk); rst = 1'b0;
    press(K1); press(K2);
    chk("R2 old slot1 code rejected", 1'b0, 3'b000);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    press(K1); press(4'hC); press(K3);
    chk("R2 new slot1 code accepted", 1'b1, 3'b000);
  endtask

  initial begin
    t_reset_state();
    t_good_seq();
    t_open_sticky();
    for (int k = 0; k < 3; k++) t_mismatch(k);
    t_bits();
    t_reset_prio();
    t_load_window();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got cycle=%0d, expected below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule